// File: doc/BRIEF.md
# Configurable GPIO Bank with Sticky Wake

This block is a bank of general-purpose pins. Four per-pin control registers set each pin's behaviour. The direction register makes a pin an output or an input. The driver register picks push-pull or open-drain drive. The latch register picks a level-following status bit or a sticky one. The wake-enable register decides which status bits feed a single shared wake/interrupt output.

One register address serves two purposes. A write to it loads the output data. A read from it returns the input status. Writing 0 to a sticky status bit through that same address clears the bit.

Pad inputs pass through a two-flop synchroniser before they reach the status register. The pad side is a set of plain per-pin output-data, output-enable and input signals. Pull-ups outside the block are represented only by the reset state, in which every pin is an input.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset every pin is an input with `pad_oe` all 0. The driver, latch and wake-enable registers read 0, the output data is 0, the status is 0 and `wake` is 0. The direction register reads all ones.
- R2: Address 0 is the direction register. A bit value of 0 makes the pin an output and 1 makes it an input. An input pin never drives: its `pad_oe` bit is 0.
- R3: Address 1 is the driver register, with 0 meaning push-pull. An output pin in push-pull mode has `pad_oe` = 1 and `pad_out` = its output data bit.
- R4: A driver bit of 1 means open drain. An open-drain output pin with data 0 drives `pad_oe` = 1 and `pad_out` = 0. With data 1 it releases the pin: `pad_oe` = 0, and `pad_out` stays 0.
- R5: A read of address 4 returns the status. A non-sticky status bit equals the pad input as it stood before the third rising clock edge after the change: two synchroniser stages plus the status register.
- R6: Address 2 is the latch register, with 1 meaning sticky. A sticky status bit sets while its synchronised input is 1. It stays set after the input falls. Writing 0 to that bit at address 4 clears it, and writing 1 leaves it unchanged.
- R7: A write to address 4 loads the output data register, which is seen on `pad_out` and `pad_oe`.
- R8: Address 3 is the wake-enable register. `wake` is 1 exactly when some status bit is 1 and its wake-enable bit is also 1.
- R9: Addresses 0 to 3 read back the value last written to them. Addresses 5 to 7 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NPIN | Write data |
| reg_rdata | output | NPIN | Read data for reg_addr (combinational) |
| pad_in | input | NPIN | Pad input levels (asynchronous) |
| pad_out | output | NPIN | Pad output data |
| pad_oe | output | NPIN | Pad output enable |
| wake | output | 1 | Shared wake/interrupt request |

## Verification
A wrong direction or driver bit shows at once on `pad_oe` or `pad_out`, on the edge that wrote the register. A wrong status or sticky state shows on an address-4 read and on `wake`. Such a fault appears either three edges after a pad change or one edge after a clearing write. The bench reads status both one edge before and exactly at the expected update, so an extra or missing synchroniser stage is caught. It also checks that a sticky bit survives both a falling input and a write of 1.

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank #(
  parameter int NPIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic            wake
);
  localparam logic [2:0] A_DIR = 3'd0, A_DRV = 3'd1, A_LATCH = 3'd2,
                         A_WEN = 3'd3, A_DATA = 3'd4;

  logic [NPIN-1:0] dir_q, odrv_q, latch_q, wen_q, dout_q, stat_q;
  logic [NPIN-1:0] sync1_q, sync2_q, clr_mask;

  assign clr_mask = (reg_we && reg_addr == A_DATA) ? ~reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      odrv_q  <= '0;
      latch_q <= '0;
      wen_q   <= '0;
      dout_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_DIR:   dir_q   <= reg_wdata;
        A_DRV:   odrv_q  <= reg_wdata;
        A_LATCH: latch_q <= reg_wdata;
        A_WEN:   wen_q   <= reg_wdata;
        A_DATA:  dout_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      stat_q  <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      stat_q  <= (latch_q & ((stat_q & ~clr_mask) | sync2_q)) | (~latch_q & sync2_q);
    end
  end

  always_comb begin
    case (reg_addr)
      A_DIR:   reg_rdata = dir_q;
      A_DRV:   reg_rdata = odrv_q;
      A_LATCH: reg_rdata = latch_q;
      A_WEN:   reg_rdata = wen_q;
      A_DATA:  reg_rdata = stat_q;
      default: reg_rdata = '0;
    endcase
  end

  assign pad_out = dout_q & ~odrv_q;
  assign pad_oe  = ~dir_q & ~(odrv_q & dout_q);
  assign wake    = |(stat_q & wen_q);
endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [NPIN-1:0] reg_wdata,
  input logic [NPIN-1:0] pad_out,
  input logic [NPIN-1:0] pad_oe,
  input logic            wake,
  input logic [NPIN-1:0] dir_q,
  input logic [NPIN-1:0] odrv_q,
  input logic [NPIN-1:0] latch_q,
  input logic [NPIN-1:0] wen_q,
  input logic [NPIN-1:0] stat_q
);
  logic [NPIN-1:0] clr_seen;
  assign clr_seen = (reg_we && reg_addr == 3'd4) ? ~reg_wdata : '0;

  a_r2_input_pin_not_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0);

  a_r4_open_drain_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & odrv_q & pad_out) == '0);

  a_r6_sticky_holds_until_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q & latch_q) & ~stat_q & ~$past(clr_seen)) == '0));

  a_r8_wake_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((stat_q & wen_q) != '0));
endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .pad_out(pad_out), .pad_oe(pad_oe), .wake(wake),
  .dir_q(dir_q), .odrv_q(odrv_q), .latch_q(latch_q), .wen_q(wen_q),
  .stat_q(stat_q)
);

// File: tb/test_gpio_wake_bank.sv
module test_gpio_wake_bank;
  localparam int NPIN = 8;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            reg_we = 0;
  logic [2:0]      reg_addr = 0;
  logic [NPIN-1:0] reg_wdata = 0;
  logic [NPIN-1:0] reg_rdata;
  logic [NPIN-1:0] pad_in = 0;
  logic [NPIN-1:0] pad_out, pad_oe;
  logic            wake;

  typedef struct {
    string           req;
    int              kind;
    logic [NPIN-1:0] exp;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_wake_bank #(.NPIN(NPIN)) i_gpio_wake_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .wake(wake)
  );

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [NPIN-1:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = reg_rdata;
        1: act = pad_out;
        2: act = pad_oe;
        default: act = {{(NPIN-1){1'b0}}, wake};
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NPIN-1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 0;
  endtask

  task automatic push(input string r, input int k, input logic [NPIN-1:0] e);
    item_t it;
    it.req = r; it.kind = k; it.exp = e;
    q.push_back(it);
  endtask

  task automatic rd(input string r, input logic [2:0] a, input logic [NPIN-1:0] e);
    reg_addr = a;
    push(r, 0, e);
    step();
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step();
    push("R1 oe", 2, 8'h00); push("R1 out", 1, 8'h00); push("R1 wake", 3, 8'h00);
    rd("R1 dir", 3'd0, 8'hFF);
    rd("R1 drv", 3'd1, 8'h00);
    rd("R1 latch", 3'd2, 8'h00);
    rd("R1 wen", 3'd3, 8'h00);
    rd("R1 status", 3'd4, 8'h00);

    wr(3'd1, 8'h5A); rd("R9 drv readback", 3'd1, 8'h5A);
    wr(3'd2, 8'hA5); rd("R9 latch readback", 3'd2, 8'hA5);
    wr(3'd3, 8'h3C); rd("R9 wen readback", 3'd3, 8'h3C);
    wr(3'd5, 8'hAA); rd("R9 addr5 zero", 3'd5, 8'h00);
    rd("R9 addr5 write ignored", 3'd1, 8'h5A);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);

    wr(3'd0, 8'hF0); wr(3'd1, 8'h0C); wr(3'd4, 8'h05);
    push("R3 R4 out", 1, 8'h01);
    push("R2 R3 R4 oe", 2, 8'h0B);
    step();
    wr(3'd4, 8'h0A);
    push("R7 out", 1, 8'h02);
    push("R4 R7 oe", 2, 8'h07);
    step();
    wr(3'd0, 8'hFF);
    push("R2 all inputs oe", 2, 8'h00);
    step();

    pad_in = 8'h30;
    step(2);
    rd("R5 status before third edge", 3'd4, 8'h00);
    rd("R5 status at third edge", 3'd4, 8'h30);
    pad_in = 8'h00;
    step(3);
    rd("R5 status follows low", 3'd4, 8'h00);

    wr(3'd2, 8'h40);
    pad_in = 8'h40;
    step(3);
    rd("R6 sticky set", 3'd4, 8'h40);
    pad_in = 8'h00;
    step(4);
    rd("R6 sticky holds", 3'd4, 8'h40);
    wr(3'd4, 8'hFF);
    rd("R6 write 1 keeps", 3'd4, 8'h40);
    wr(3'd4, 8'hBF);
    rd("R6 write 0 clears", 3'd4, 8'h00);

    pad_in = 8'h40;
    step(3);
    pad_in = 8'h00;
    step(3);
    push("R8 wake masked", 3, 8'h00);
    step();
    wr(3'd3, 8'h40);
    push("R8 wake enabled", 3, 8'h01);
    step();
    wr(3'd3, 8'h80);
    push("R8 other enable", 3, 8'h00);
    step();
    wr(3'd3, 8'h40);
    wr(3'd4, 8'h00);
    push("R8 wake after clear", 3, 8'h00);
    step(2);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule